// File: doc/BRIEF.md
# I2C Register-File Slave

This block is an I2C target that lets a bus host read and write a bank of six 8-bit control registers. The block works in the clock domain of a fast system clock. The SCL and SDA pins are brought into that domain through a synchronizer. From the synchronized lines the block finds start, repeated-start and stop conditions and SCL edges. A single state machine follows each transfer bit by bit. The block answers only to one fixed 7-bit device address.

A write transfer carries the device address with the direction bit at 0, then a register pointer, then one data byte. The block acknowledges all three bytes and stores the data byte in the selected register. A read transfer carries the address with direction 0 and the pointer. The host then issues a repeated start and sends the address again with direction 1. The block sends back one byte from the register that the pointer selected, and the host ends with a NACK and a stop. Each transfer moves exactly one register. Any further access resends the pointer.

The register contents appear on a flat parallel output that the surrounding logic can read at any time. That output is a level, not a stream, so it carries no valid/ready handshake. The block has no back-pressure path: it never stretches SCL, so the bus host sets the pace. The SDA pin is open drain. The block provides only an enable that pulls the line low, and SCL is only an input.

Top module: `i2c_regfile_slave`

## Requirements
- R1: A write transfer (start, address+0, pointer, data, stop) to a pointer in 0..5 gets an ACK (SDA low on the ninth clock) for all three bytes. The data byte then appears on `regs_o` bits [8p+7:8p], where p is the pointer.
- R2: A read transfer (start, address+0, pointer, repeated start, address+1) is acknowledged. The block then shifts out the selected register MSB first, one bit per SCL clock.
- R3: The block acknowledges only its own 7-bit address (default 0x4A). The general-call address 0x00 and the 10-bit header range 0x78..0x7B get no ACK, and transfers to them leave every register unchanged.
- R4: Pointers 6..255 are still acknowledged. A write to such a pointer changes no register, and a read from it returns 0x00.
- R5: A transfer writes exactly one register. A second data byte sent before the stop gets no ACK and changes no register, because the pointer never auto-increments.
- R6: A repeated start is accepted at any point and restarts address matching without a stop. After a repeated start, a non-matching address gets no ACK.
- R7: A stop received in the middle of a byte returns the block to idle and does not commit the partial byte. The next transfer works normally.
- R8: The block changes its SDA drive only while SCL is low. It releases SDA for the host's acknowledge slot after the read byte.
- R9: Transfers work at 100 kbit/s and at 400 kbit/s with the default 50 MHz system clock.
- R10: After reset, all registers read 0x00 on `regs_o` and SDA is not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 48 | Register p on bits [8p+7:8p] |

## Verification
A state machine that drifts out of step with the bus first shows up as an ACK or a data bit in the wrong slot. The bench sees this on the same byte, within nine SCL periods. A wrong pointer or a missed write-commit gate shows up on `regs_o` one system clock after the eighth data bit. A wrong abort on stop or on repeated start shows up in the next transfer, as a missing ACK or a wrong read byte. An SDA change while SCL is high breaks the bus rules at once, and a monitor that watches every system clock catches it.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_PTR,
    S_PACK,
    S_WDATA,
    S_WACK,
    S_RDATA,
    S_RACK,
    S_IGNORE
  } i2cr_state_e;
endpackage

// File: rtl/i2cr_line_cond.sv
module i2cr_line_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // index 1 = scl, index 0 = sda; idle bus is high
  logic [1:0] stg [STAGES];
  logic [1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= 2'b11;
      prev_q <= 2'b11;
    end else begin
      stg[0] <= {scl_i, sda_i};
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev_q <= stg[STAGES-1];
    end
  end

  logic scl_now, sda_now;
  assign scl_now    = stg[STAGES-1][1];
  assign sda_now    = stg[STAGES-1][0];
  assign sda_s_o    = sda_now;
  assign scl_rise_o = scl_now & ~prev_q[1];
  assign scl_fall_o = ~scl_now & prev_q[1];
  assign start_o    = scl_now & prev_q[1] & prev_q[0] & ~sda_now;
  assign stop_o     = scl_now & prev_q[1] & ~prev_q[0] & sda_now;
endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned DW       = 8,
  parameter int unsigned PW       = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [PW-1:0]          ptr_i,
  input  logic [DW-1:0]          wr_data_i,
  output logic [DW-1:0]          rd_data_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (wr_en_i && ptr_i == PW'(g))     q <= wr_data_i;
    end
    assign regs_o[g*DW +: DW] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr_i == PW'(i)) rd_data_o = regs_o[i*DW +: DW];
  end

  AST_HIGH_PTR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && (ptr_i >= PW'(NUM_REGS)) |=> $stable(regs_o)); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && (ptr_i < PW'(NUM_REGS)) |=> rd_data_o == $past(wr_data_i)); // R1
endmodule

// File: rtl/i2cr_fsm.sv
module i2cr_fsm
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  i2cr_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw;
  logic [BYTE_W-1:0] nxt_byte;
  logic              byte_done;

  assign nxt_byte  = {sh[BYTE_W-2:0], sda_s_i};
  assign byte_done = scl_rise_i && (cnt == CNT_W'(BYTE_W - 1));
  assign wr_data_o = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0;
      ptr_o <= '0; sda_oe_o <= 1'b0; wr_en_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        state <= S_IDLE; sda_oe_o <= 1'b0; cnt <= '0;
      end else if (start_i) begin
        state <= S_ADDR; sda_oe_o <= 1'b0; cnt <= '0;
      end else begin
        unique case (state)
          S_ADDR, S_PTR, S_WDATA: if (scl_rise_i) begin
            sh  <= nxt_byte;
            cnt <= byte_done ? '0 : cnt + 1'b1;
            if (byte_done) begin
              if (state == S_ADDR) begin
                if (nxt_byte[BYTE_W-1:1] == DEV_ADDR) begin
                  rw <= nxt_byte[0]; state <= S_AACK;
                end else state <= S_IGNORE;
              end else if (state == S_PTR) begin
                ptr_o <= nxt_byte; state <= S_PACK;
              end else begin
                wr_en_o <= 1'b1; state <= S_WACK;
              end
            end
          end
          S_AACK, S_PACK, S_WACK: if (scl_fall_i) begin
            if (!sda_oe_o) sda_oe_o <= 1'b1;
            else begin
              sda_oe_o <= 1'b0;
              if (state == S_AACK && rw) begin
                sh <= rd_data_i; sda_oe_o <= ~rd_data_i[BYTE_W-1];
                state <= S_RDATA;
              end else if (state == S_AACK) state <= S_PTR;
              else if (state == S_PACK)     state <= S_WDATA;
              else                          state <= S_IGNORE;
            end
          end
          S_RDATA: begin
            if (scl_rise_i) cnt <= cnt + 1'b1;
            else if (scl_fall_i) begin
              if (cnt == CNT_W'(BYTE_W)) begin
                sda_oe_o <= 1'b0; cnt <= '0; state <= S_RACK;
              end else begin
                sh <= sh << 1; sda_oe_o <= ~sh[BYTE_W-2];
              end
            end
          end
          S_RACK: if (scl_rise_i) state <= S_IGNORE;
          default: ;
        endcase
      end
    end
  end

  AST_OE_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i)); // R8
  AST_ACK_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) && state == S_AACK |-> sh[BYTE_W-1:1] == DEV_ADDR); // R3
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (state == S_IDLE) && !sda_oe_o); // R7
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o); // R5
  AST_RACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RACK |-> !sda_oe_o); // R8
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2cr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h4A,
  parameter int unsigned NUM_REGS    = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic sda_s, scl_rise, scl_fall, start, stop, wr_en;
  logic [BYTE_W-1:0] ptr, wr_data, rd_data;

  i2cr_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2cr_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe_o), .wr_en_o(wr_en),
    .ptr_o(ptr), .wr_data_o(wr_data)
  );

  i2cr_regbank #(.NUM_REGS(NUM_REGS), .DW(BYTE_W), .PW(BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .ptr_i(ptr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .regs_o(regs_o)
  );
endmodule

// File: tb/i2c_regfile_slave_bench.sv
module i2c_regfile_slave_bench;
  localparam logic [6:0] DEV = 7'h4A;
  localparam int NREG = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_regfile_slave u_i2c_regfile_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs_o)
  );

  int q = 32;
  int checks = 0;
  int fails = 0;
  int viol = 0;
  logic [7:0] exp_regs [NREG];
  logic prev_oe = 1'b0;

  // R8 monitor: SDA drive may change only while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && m_scl) viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] p);
    return (p < NREG) ? exp_regs[p] : 8'h00;
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) check(req, regs_o[8*i +: 8], exp_regs[i]);
  endtask

  task automatic qw();
    repeat (q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
    ack = ~sda_line;
    qw(); m_scl = 1'b0; qw();
  endtask

  task automatic recv_byte(output logic [7:0] d, output logic rel);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
      d = {d[6:0], sda_line};
      qw(); m_scl = 1'b0; qw();
    end
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
    rel = sda_line;
    qw(); m_scl = 1'b0; qw();
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                        output logic [2:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[2]);
    send_byte(p, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d,
                        output logic [2:0] acks, output logic rel);
    bus_start();
    send_byte({a, 1'b0}, acks[2]);
    send_byte(p, acks[1]);
    bus_start();
    send_byte({a, 1'b1}, acks[0]);
    recv_byte(d, rel);
    bus_stop();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic rel, ack;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    check("R10 oe", sda_oe, 0);
    check_regs("R10 regs");

    // R1 directed write
    wr_txn(DEV, 8'd2, 8'hA5, acks);
    exp_regs[2] = 8'hA5;
    check("R1 acks", acks, 3'b111);
    check_regs("R1 regs");

    // R2 / R6 / R8 read back with repeated start
    rd_txn(DEV, 8'd2, d, acks, rel);
    check("R2 acks", acks, 3'b111);
    check("R2 data", d, 8'hA5);
    check("R8 released", rel, 1);

    // R3 general call and 10-bit header
    wr_txn(7'h00, 8'd1, 8'hFF, acks);
    check("R3 gencall ack", acks[2], 0);
    wr_txn(7'h78, 8'd1, 8'hFF, acks);
    check("R3 10bit ack", acks[2], 0);
    wr_txn(7'h7B, 8'd1, 8'hFF, acks);
    check("R3 10bit hi ack", acks[2], 0);
    check_regs("R3 regs");

    // R4 out-of-range pointers
    wr_txn(DEV, 8'd7, 8'h3C, acks);
    check("R4 acks", acks, 3'b111);
    check_regs("R4 regs");
    wr_txn(DEV, 8'd255, 8'h3C, acks);
    check("R4 acks 255", acks, 3'b111);
    check_regs("R4 regs 255");
    rd_txn(DEV, 8'd200, d, acks, rel);
    check("R4 read", d, 8'h00);

    // R5 second data byte
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'd3, ack);
    send_byte(8'h11, ack);
    check("R5 first ack", ack, 1);
    send_byte(8'h22, ack);
    check("R5 extra ack", ack, 0);
    bus_stop();
    exp_regs[3] = 8'h11;
    check_regs("R5 regs");

    // R7 stop in middle of data byte
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'd5, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check_regs("R7 regs");
    rd_txn(DEV, 8'd5, d, acks, rel);
    check("R7 next acks", acks, 3'b111);
    check("R7 next data", d, 8'h00);

    // R6 repeated start to another address
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'd1, ack);
    bus_start();
    send_byte({7'h4B, 1'b1}, ack);
    check("R6 mismatch ack", ack, 0);
    bus_stop();

    // random mix at 400 kbit/s (R1, R2, R4)
    for (int it = 0; it < 10; it++) begin
      logic [7:0] p, v;
      p = 8'($urandom_range(0, 7));
      v = 8'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        wr_txn(DEV, p, v, acks);
        if (p < NREG) exp_regs[p] = v;
        check("R1 rnd acks", acks, 3'b111);
        check_regs("R1 R4 rnd regs");
      end else begin
        rd_txn(DEV, p, d, acks, rel);
        check("R2 rnd data", d, exp_read(p));
        check("R8 rnd rel", rel, 1);
      end
    end

    // R9 100 kbit/s
    q = 125;
    wr_txn(DEV, 8'd0, 8'h5A, acks);
    exp_regs[0] = 8'h5A;
    check("R9 slow acks", acks, 3'b111);
    check_regs("R9 slow regs");
    rd_txn(DEV, 8'd0, d, acks, rel);
    check("R9 slow data", d, 8'h5A);

    check("R8 drive only while SCL low", viol, 0);
    report();
    $finish;
  end
endmodule